// File: doc/BRIEF.md
# Multicycle Fetch-Execute-Writeback Sequencer

This block is the control core of a small non-pipelined processor. It works on one instruction at a time. It fetches the word at the program counter, executes it, and for loads only it passes through a writeback phase. Instruction memory and data memory sit behind separate valid/ready request and response channels. Each response may arrive any number of cycles after its request, and the sequencer waits in its current phase until that response shows up. The state it holds is the program counter, an eight-entry register file whose entry 0 always reads zero, and a latch that keeps the destination index of a pending load.

Instructions are 32 bits wide with these fields: opcode in [31:28], destination index in [27:25], first source index in [24:22], second source index in [21:19], and a signed 16-bit offset in [15:0]. Bits [18:16] are ignored. The opcodes are ADD=1, SUB=2, LW=3, SW=4 and BEQZ=5. The all-ones word stops the machine. Any other opcode acts as a no-op. The program counter is a byte address that advances by 4.

Top module: `mc_seq_core`

## Requirements
- R1: While reset is held, no request and no response-ready output is asserted and `halt` is low. After release, the first instruction fetch is at address 0.
- R2: An instruction request stays asserted, with a stable address, until it is accepted. After acceptance no new fetch is issued until that instruction's response has been consumed.
- R3: ADD (opcode 1) writes src1 + src2 + sext(offset) to the destination. SUB (opcode 2) writes src1 - src2 + sext(offset). Either one is followed by a fetch at PC+4.
- R4: Register 0 always reads as zero. A write that targets it has no effect.
- R5: LW (opcode 3) issues a data read at src1 + sext(offset), records the destination index, and waits in writeback for the response. It writes the returned word to that register, then fetches again.
- R6: SW (opcode 4) issues a data write of the second source register to src1 + sext(offset). It returns directly to fetch and never waits for a data response.
- R7: BEQZ (opcode 5) jumps to PC + 4 + 4*sext(offset) when the first source register is zero. Otherwise it continues at PC + 4. Negative offsets jump backwards.
- R8: Any response delay is tolerated. At most one request per memory is outstanding, and each response is consumed exactly once.
- R9: The all-ones instruction word asserts `halt`. `halt` then stays high and no further fetch is issued until reset.
- R10: An instruction word whose opcode is not listed and which is not all ones changes no register and continues at PC + 4.
- R11: For a load or store, the instruction response is consumed in the same cycle that the data request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_req_valid | output | 1 | Instruction fetch request valid |
| imem_req_ready | input | 1 | Instruction memory accepts request |
| imem_req_addr | output | XLEN | Fetch byte address (PC) |
| imem_rsp_valid | input | 1 | Instruction word available |
| imem_rsp_ready | output | 1 | Sequencer consumes instruction word |
| imem_rsp_data | input | 32 | Instruction word |
| dmem_req_valid | output | 1 | Data request valid |
| dmem_req_ready | input | 1 | Data memory accepts request |
| dmem_req_we | output | 1 | 1 = write, 0 = read |
| dmem_req_addr | output | XLEN | Data byte address |
| dmem_req_wdata | output | XLEN | Store data |
| dmem_rsp_valid | input | 1 | Read data available |
| dmem_rsp_ready | output | 1 | Sequencer consumes read data |
| dmem_rsp_data | input | XLEN | Read data |
| halt | output | 1 | Halt instruction executed |

## Verification
The bench uses the default build: 32-bit data, eight registers, reset PC 0. Its memory model has small arrays whose instruction latency, data latency and ready-stall pattern can each be set per run. It sweeps operand pairs that hit the sign and carry boundaries, together with offsets of 0, -1, 0x7FFF and 0x8000, across those latency and stall combinations, so loads, stores and the waits in every phase all occur. A second program counts down a loop with a backward branch and also covers a taken forward branch, an untaken branch and an unlisted opcode. The fetch counts and stored words from that program show the exact instruction path taken.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

  localparam int INSTR_W = 32;
  localparam int OPC_LSB = 28;
  localparam int OPC_W   = 4;
  localparam int RD_LSB  = 25;
  localparam int RS1_LSB = 22;
  localparam int RS2_LSB = 19;
  localparam int IMM_W   = 16;

  typedef enum logic [OPC_W-1:0] {
    OPC_ADD  = 4'h1,
    OPC_SUB  = 4'h2,
    OPC_LW   = 4'h3,
    OPC_SW   = 4'h4,
    OPC_BEQZ = 4'h5
  } opcode_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_FETCH,
    PH_EXEC,
    PH_WBACK,
    PH_HALT
  } phase_e;

  typedef enum logic [2:0] {
    K_NOP,
    K_ALU,
    K_LOAD,
    K_STORE,
    K_BRANCH,
    K_HALT
  } kind_e;

endpackage

// File: rtl/mc_seq_regfile.sv
module mc_seq_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  parameter int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            we,
  input  logic [RIDX-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RIDX-1:0] raddr_a,
  input  logic [RIDX-1:0] raddr_b,
  output logic [XLEN-1:0] rdata_a,
  output logic [XLEN-1:0] rdata_b
);

  logic [NREG*XLEN-1:0] flat;

  for (genvar g = 0; g < NREG; g++) begin : g_entry
    if (g == 0) begin : g_zero
      assign flat[g*XLEN +: XLEN] = '0;
    end else begin : g_store
      logic [XLEN-1:0] q;
      logic            en;
      assign en = we && (waddr == RIDX'(g));
      always_ff @(posedge clk) begin
        if (en) q <= wdata;
      end
      assign flat[g*XLEN +: XLEN] = q;
    end
  end

  assign rdata_a = flat[raddr_a*XLEN +: XLEN];
  assign rdata_b = flat[raddr_b*XLEN +: XLEN];

endmodule

// File: rtl/mc_seq_exec.sv
module mc_seq_exec
  import mc_seq_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RIDX = 3
) (
  input  logic [INSTR_W-1:0] instr,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    rs1_val,
  input  logic [XLEN-1:0]    rs2_val,
  output kind_e              kind,
  output logic [RIDX-1:0]    rd_idx,
  output logic [RIDX-1:0]    rs1_idx,
  output logic [RIDX-1:0]    rs2_idx,
  output logic [XLEN-1:0]    alu_res,
  output logic [XLEN-1:0]    mem_addr,
  output logic [XLEN-1:0]    next_pc
);

  logic [OPC_W-1:0] opc;
  logic [XLEN-1:0]  imm_ext;
  logic [XLEN-1:0]  seq_pc;
  logic [XLEN-1:0]  br_pc;
  logic [2:0]       unused_pad;

  assign unused_pad = instr[18:16];

  always_comb begin
    opc      = instr[OPC_LSB +: OPC_W];
    rd_idx   = instr[RD_LSB  +: RIDX];
    rs1_idx  = instr[RS1_LSB +: RIDX];
    rs2_idx  = instr[RS2_LSB +: RIDX];
    imm_ext  = {{(XLEN-IMM_W){instr[IMM_W-1]}}, instr[IMM_W-1:0]};
    seq_pc   = pc + XLEN'(4);
    br_pc    = seq_pc + (imm_ext << 2);
    mem_addr = rs1_val + imm_ext;

    if (&instr) begin
      kind = K_HALT;
    end else begin
      unique case (opc)
        OPC_ADD, OPC_SUB: kind = K_ALU;
        OPC_LW:           kind = K_LOAD;
        OPC_SW:           kind = K_STORE;
        OPC_BEQZ:         kind = K_BRANCH;
        default:          kind = K_NOP;
      endcase
    end

    if (opc == OPC_SUB) alu_res = rs1_val - rs2_val + imm_ext;
    else                alu_res = rs1_val + rs2_val + imm_ext;

    if (kind == K_BRANCH && rs1_val == '0) next_pc = br_pc;
    else                                   next_pc = seq_pc;
  end

endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
  import mc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  kind_e  kind,
  input  logic   imem_req_ready,
  input  logic   imem_rsp_valid,
  input  logic   dmem_req_ready,
  input  logic   dmem_rsp_valid,
  output phase_e phase,
  output logic   imem_req_valid,
  output logic   imem_rsp_ready,
  output logic   dmem_req_valid,
  output logic   dmem_rsp_ready,
  output logic   ex_fire,
  output logic   wb_fire
);

  phase_e phase_q, phase_d;
  logic   is_mem;

  always_comb begin
    phase_d        = phase_q;
    imem_req_valid = 1'b0;
    imem_rsp_ready = 1'b0;
    dmem_req_valid = 1'b0;
    dmem_rsp_ready = 1'b0;
    ex_fire        = 1'b0;
    wb_fire        = 1'b0;
    is_mem         = (kind == K_LOAD) || (kind == K_STORE);

    unique case (phase_q)
      PH_IDLE: phase_d = PH_FETCH;
      PH_FETCH: begin
        imem_req_valid = 1'b1;
        if (imem_req_ready) phase_d = PH_EXEC;
      end
      PH_EXEC: begin
        imem_rsp_ready = is_mem ? dmem_req_ready : 1'b1;
        dmem_req_valid = is_mem && imem_rsp_valid;
        ex_fire        = imem_rsp_valid && imem_rsp_ready;
        if (ex_fire) begin
          unique case (kind)
            K_LOAD:  phase_d = PH_WBACK;
            K_HALT:  phase_d = PH_HALT;
            default: phase_d = PH_FETCH;
          endcase
        end
      end
      PH_WBACK: begin
        dmem_rsp_ready = 1'b1;
        wb_fire        = dmem_rsp_valid;
        if (dmem_rsp_valid) phase_d = PH_FETCH;
      end
      PH_HALT: phase_d = PH_HALT;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase = phase_q;

endmodule

// File: rtl/mc_seq_core.sv
module mc_seq_core
  import mc_seq_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              NREG     = 8,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               imem_req_valid,
  input  logic               imem_req_ready,
  output logic [XLEN-1:0]    imem_req_addr,
  input  logic               imem_rsp_valid,
  output logic               imem_rsp_ready,
  input  logic [INSTR_W-1:0] imem_rsp_data,
  output logic               dmem_req_valid,
  input  logic               dmem_req_ready,
  output logic               dmem_req_we,
  output logic [XLEN-1:0]    dmem_req_addr,
  output logic [XLEN-1:0]    dmem_req_wdata,
  input  logic               dmem_rsp_valid,
  output logic               dmem_rsp_ready,
  input  logic [XLEN-1:0]    dmem_rsp_data,
  output logic               halt
);

  localparam int RIDX = $clog2(NREG);

  logic [1:0]      rst_sync_q;
  logic            core_rst_n;
  logic [XLEN-1:0] pc_q;
  logic [RIDX-1:0] dst_q;
  kind_e           kind;
  phase_e          phase;
  logic [RIDX-1:0] rd_idx, rs1_idx, rs2_idx;
  logic [XLEN-1:0] rs1_val, rs2_val, alu_res, mem_addr, next_pc;
  logic            ex_fire, wb_fire;
  logic            rf_we;
  logic [RIDX-1:0] rf_waddr;
  logic [XLEN-1:0] rf_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  mc_seq_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (core_rst_n),
    .kind           (kind),
    .imem_req_ready (imem_req_ready),
    .imem_rsp_valid (imem_rsp_valid),
    .dmem_req_ready (dmem_req_ready),
    .dmem_rsp_valid (dmem_rsp_valid),
    .phase          (phase),
    .imem_req_valid (imem_req_valid),
    .imem_rsp_ready (imem_rsp_ready),
    .dmem_req_valid (dmem_req_valid),
    .dmem_rsp_ready (dmem_rsp_ready),
    .ex_fire        (ex_fire),
    .wb_fire        (wb_fire)
  );

  mc_seq_exec #(.XLEN(XLEN), .RIDX(RIDX)) u_exec (
    .instr    (imem_rsp_data),
    .pc       (pc_q),
    .rs1_val  (rs1_val),
    .rs2_val  (rs2_val),
    .kind     (kind),
    .rd_idx   (rd_idx),
    .rs1_idx  (rs1_idx),
    .rs2_idx  (rs2_idx),
    .alu_res  (alu_res),
    .mem_addr (mem_addr),
    .next_pc  (next_pc)
  );

  always_comb begin
    rf_we    = (ex_fire && kind == K_ALU) || wb_fire;
    rf_waddr = wb_fire ? dst_q : rd_idx;
    rf_wdata = wb_fire ? dmem_rsp_data : alu_res;
  end

  mc_seq_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk     (clk),
    .we      (rf_we),
    .waddr   (rf_waddr),
    .wdata   (rf_wdata),
    .raddr_a (rs1_idx),
    .raddr_b (rs2_idx),
    .rdata_a (rs1_val),
    .rdata_b (rs2_val)
  );

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)  pc_q <= RESET_PC;
    else if (ex_fire) pc_q <= next_pc;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)                   dst_q <= '0;
    else if (ex_fire && kind == K_LOAD) dst_q <= rd_idx;
  end

  assign imem_req_addr  = pc_q;
  assign dmem_req_we    = (kind == K_STORE);
  assign dmem_req_addr  = mem_addr;
  assign dmem_req_wdata = rs2_val;
  assign halt           = (phase == PH_HALT);

endmodule

// File: rtl/mc_seq_core_chk.sv
module mc_seq_core_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            imem_req_valid,
  input logic            imem_req_ready,
  input logic [XLEN-1:0] imem_req_addr,
  input logic            imem_rsp_valid,
  input logic            imem_rsp_ready,
  input logic            dmem_req_valid,
  input logic            dmem_req_ready,
  input logic            dmem_req_we,
  input logic            dmem_rsp_valid,
  input logic            dmem_rsp_ready,
  input logic            halt
);

  assert_fetch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req_valid && !imem_req_ready |=> imem_req_valid && $stable(imem_req_addr));

  assert_single_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req_valid && imem_req_ready |=> !imem_req_valid);

  assert_phase_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    imem_req_valid |-> !imem_rsp_ready && !dmem_req_valid && !dmem_rsp_ready);

  assert_mem_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_req_valid |-> imem_rsp_valid && (imem_rsp_ready == dmem_req_ready));

  assert_store_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_req_valid && dmem_req_ready && dmem_req_we |=> !dmem_rsp_ready && imem_req_valid);

  assert_load_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_req_valid && dmem_req_ready && !dmem_req_we |=> dmem_rsp_ready);

  assert_wb_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rsp_valid && dmem_rsp_ready |=> !dmem_rsp_ready && imem_req_valid);

  assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt && !imem_req_valid);

endmodule

bind mc_seq_core mc_seq_core_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/mc_seq_core_test.sv
module mc_seq_core_test;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] T_ADD = 4'h1, T_SUB = 4'h2, T_LW = 4'h3, T_SW = 4'h4, T_BZ = 4'h5;
  localparam logic [31:0] HALT_W = 32'hFFFF_FFFF;
  localparam logic [31:0] SENT   = 32'hDEAD_BEEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imem_req_valid, imem_req_ready;
  logic [31:0] imem_req_addr;
  logic        imem_rsp_valid, imem_rsp_ready;
  logic [31:0] imem_rsp_data;
  logic        dmem_req_valid, dmem_req_ready, dmem_req_we;
  logic [31:0] dmem_req_addr, dmem_req_wdata;
  logic        dmem_rsp_valid, dmem_rsp_ready;
  logic [31:0] dmem_rsp_data;
  logic        halt;

  mc_seq_core uut (
    .clk(clk), .rst_n(rst_n),
    .imem_req_valid(imem_req_valid), .imem_req_ready(imem_req_ready), .imem_req_addr(imem_req_addr),
    .imem_rsp_valid(imem_rsp_valid), .imem_rsp_ready(imem_rsp_ready), .imem_rsp_data(imem_rsp_data),
    .dmem_req_valid(dmem_req_valid), .dmem_req_ready(dmem_req_ready), .dmem_req_we(dmem_req_we),
    .dmem_req_addr(dmem_req_addr), .dmem_req_wdata(dmem_req_wdata),
    .dmem_rsp_valid(dmem_rsp_valid), .dmem_rsp_ready(dmem_rsp_ready), .dmem_rsp_data(dmem_rsp_data),
    .halt(halt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] rom  [0:31];
  logic [31:0] dram [0:31];

  int n_checks = 0, n_fail = 0;
  int ilat = 0, dlat = 0, stall = 0, cyc = 0;
  int i_cnt, d_cnt, fetches, stores, loads;
  bit i_pend, d_pend, f_ireq, f_irsp, f_dreq, f_drsp, last_we, seen_fetch;
  logic [31:0] i_addr, d_addr, q_iaddr, q_daddr, q_wdata, prev_addr, first_addr;
  bit q_we, prev_stall;
  int viol_r2 = 0, viol_r6 = 0, viol_r8 = 0, viol_r11 = 0;

  // memory model: effects at negedge, handshake decisions 1 time unit later
  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      i_pend = 0; d_pend = 0; f_ireq = 0; f_irsp = 0; f_dreq = 0; f_drsp = 0;
      imem_rsp_valid = 0; dmem_rsp_valid = 0; imem_rsp_data = '0; dmem_rsp_data = '0;
      fetches = 0; stores = 0; loads = 0; last_we = 0; seen_fetch = 0; prev_stall = 0;
      first_addr = 32'hFFFF_FFFF;
    end else begin
      if (f_irsp) imem_rsp_valid = 0;
      if (f_ireq) begin i_pend = 1; i_cnt = ilat; i_addr = q_iaddr; end
      if (f_drsp) dmem_rsp_valid = 0;
      if (f_dreq) begin
        last_we = q_we;
        if (q_we) begin dram[q_daddr[6:2]] = q_wdata; stores++; end
        else begin d_pend = 1; d_cnt = dlat; d_addr = q_daddr; loads++; end
      end
      if (i_pend) begin
        if (i_cnt == 0) begin imem_rsp_valid = 1; imem_rsp_data = rom[i_addr[6:2]]; i_pend = 0; end
        else i_cnt--;
      end
      if (d_pend) begin
        if (d_cnt == 0) begin dmem_rsp_valid = 1; dmem_rsp_data = dram[d_addr[6:2]]; d_pend = 0; end
        else d_cnt--;
      end
    end
    imem_req_ready = (stall == 0) || (cyc % (stall + 1) == 0);
    dmem_req_ready = (stall == 0) || ((cyc + 1) % (stall + 1) == 0);
    #1;
    f_ireq = rst_n && imem_req_valid && imem_req_ready;
    f_irsp = rst_n && imem_rsp_valid && imem_rsp_ready;
    f_dreq = rst_n && dmem_req_valid && dmem_req_ready;
    f_drsp = rst_n && dmem_rsp_valid && dmem_rsp_ready;
    q_iaddr = imem_req_addr; q_daddr = dmem_req_addr; q_wdata = dmem_req_wdata; q_we = dmem_req_we;
    if (rst_n) begin
      if (prev_stall && (!imem_req_valid || imem_req_addr != prev_addr)) viol_r2++;
      prev_stall = imem_req_valid && !imem_req_ready;
      prev_addr  = imem_req_addr;
      if (f_ireq && (i_pend || imem_rsp_valid)) viol_r8++;
      if (f_dreq && (d_pend || dmem_rsp_valid)) viol_r8++;
      if (f_dreq && !f_irsp) viol_r11++;
      if (dmem_rsp_ready && last_we) viol_r6++;
      if (f_ireq) begin
        if (!seen_fetch) first_addr = imem_req_addr;
        seen_fetch = 1;
        fetches++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(logic [3:0] op, logic [2:0] rd, logic [2:0] s1,
                                      logic [2:0] s2, logic [15:0] imm);
    return {op, rd, s1, s2, 3'b000, imm};
  endfunction

  task automatic clear_mem();
    for (int k = 0; k < 32; k++) begin rom[k] = HALT_W; dram[k] = SENT; end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 outputs in reset", {27'd0, imem_req_valid, imem_rsp_ready, dmem_req_valid,
        dmem_rsp_ready, halt}, 32'd0);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic run_to_halt(input int exp_fetch);
    int n = 0;
    while (!halt && n < 3000) begin @(negedge clk); #2; n++; end
    chk("R9 halt reached", {31'd0, halt}, 32'd1);
    chk("R1 first fetch address", first_addr, 32'd0);
    chk("R8 fetch count", fetches, exp_fetch);
    repeat (10) @(negedge clk);
    #2;
    chk("R9 no fetch after halt", fetches, exp_fetch);
    chk("R9 halt sticky", {31'd0, halt}, 32'd1);
  endtask

  task automatic alu_run(input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
                         input int il, input int dl, input int st);
    logic [31:0] sx;
    sx = {{16{imm[15]}}, imm};
    ilat = il; dlat = dl; stall = st;
    clear_mem();
    rom[0] = enc(T_LW, 3'd1, 3'd0, 3'd0, 16'd0);
    rom[1] = enc(T_LW, 3'd2, 3'd0, 3'd0, 16'd4);
    rom[2] = enc(T_ADD, 3'd3, 3'd1, 3'd2, imm);
    rom[3] = enc(T_SUB, 3'd4, 3'd1, 3'd2, imm);
    rom[4] = enc(T_ADD, 3'd0, 3'd1, 3'd2, 16'd5);
    rom[5] = enc(T_SW, 3'd0, 3'd0, 3'd3, 16'd8);
    rom[6] = enc(T_SW, 3'd0, 3'd0, 3'd4, 16'd12);
    rom[7] = enc(T_SW, 3'd0, 3'd0, 3'd0, 16'd16);
    rom[8] = HALT_W;
    dram[0] = a; dram[1] = b;
    do_reset();
    run_to_halt(9);
    chk("R3 add result", dram[2], a + b + sx);
    chk("R3 sub result", dram[3], a - b + sx);
    chk("R4 register 0 stays zero", dram[4], 32'd0);
    chk("R5 load count", loads, 32'd2);
    chk("R6 store count", stores, 32'd3);
  endtask

  task automatic branch_run(input int il, input int st);
    ilat = il; dlat = 1; stall = st;
    clear_mem();
    rom[0]  = enc(T_ADD, 3'd1, 3'd0, 3'd0, 16'd3);
    rom[1]  = enc(T_ADD, 3'd2, 3'd0, 3'd0, 16'd0);
    rom[2]  = enc(T_ADD, 3'd2, 3'd2, 3'd0, 16'd1);
    rom[3]  = enc(T_SUB, 3'd1, 3'd1, 3'd0, 16'hFFFF);
    rom[4]  = enc(T_BZ, 3'd0, 3'd1, 3'd0, 16'd1);
    rom[5]  = enc(T_BZ, 3'd0, 3'd0, 3'd0, 16'hFFFC);
    rom[6]  = enc(T_SW, 3'd0, 3'd0, 3'd2, 16'd16);
    rom[7]  = enc(T_ADD, 3'd3, 3'd0, 3'd0, 16'd7);
    rom[8]  = enc(T_BZ, 3'd0, 3'd0, 3'd0, 16'd1);
    rom[9]  = enc(T_SW, 3'd0, 3'd0, 3'd3, 16'd20);
    rom[10] = 32'hE000_0000;
    rom[11] = enc(T_SW, 3'd0, 3'd0, 3'd3, 16'd24);
    rom[12] = HALT_W;
    do_reset();
    run_to_halt(19);
    chk("R7 backward loop count", dram[4], 32'd3);
    chk("R7 taken branch skips store", dram[5], SENT);
    chk("R10 unlisted opcode is no-op", dram[6], 32'd7);
    chk("R6 store count", stores, 32'd2);
  endtask

  logic [31:0] va [6] = '{32'h0, 32'h1, 32'h7FFF_FFFF, 32'h8000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
  logic [31:0] vb [3] = '{32'hFFFF_FFFF, 32'h3, 32'h8000_0000};
  logic [15:0] vi [4] = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000};
  bit done = 0;

  initial begin
    imem_req_ready = 0; dmem_req_ready = 0;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 3; j++)
        alu_run(va[i], vb[j], vi[(i + j) % 4], i % 3, (j * 2) % 5, (i + j) % 3);
    alu_run(32'h0000_00FF, 32'h0000_0100, 16'h8000, 9, 25, 2);
    branch_run(0, 0);
    branch_run(4, 2);
    chk("R2 fetch request hold", viol_r2, 32'd0);
    chk("R6 no wait after store", viol_r6, 32'd0);
    chk("R8 single outstanding", viol_r8, 32'd0);
    chk("R11 paired consume", viol_r11, 32'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    for (int w = 0; w < 150000; w++) @(negedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog R8: actual hung expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule